// File: doc/BRIEF.md
# Scoreboard Issue Controller

This block is the central interlock controller of a floating-point pipeline with five functional units: one load/integer unit, two multipliers, one add/subtract unit and one divider. Decoded instructions arrive in program order, each with an operation class, a destination register and two source registers. The controller issues them strictly in order. Each issued instruction then waits on its own for its operands, runs for the fixed latency of its unit and competes for the single register-file write port. Operand reads, completions and write-backs may therefore happen in a different order from issue.

The controller keeps three tables. Per unit it stores the destination, the two sources, the producing unit of each source and a ready flag per source. Per register it stores which unit will write it next, or zero if no write is pending. Issue stalls on a busy unit or on a pending write to the same destination (WAW). Operand read waits for both sources (RAW). Write-back waits while any unit still has to read the old value of the destination (WAR). There is no renaming. The execution units are latency counters inside the block. The trace outputs pulse for every stage event, and a free-running cycle counter lets a bench time-stamp each event.

The instruction input uses a valid/ready handshake. While `in_valid` is high and `in_ready` is low, the source must hold the instruction stable. An instruction transfers in the cycle where both are high. `in_ready` depends on the class and destination presented, so it may change while the instruction waits. It never depends on `in_valid`.

Top module: `sb_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, no unit is busy and no register has a pending writer: `in_ready` is high, `wb_valid`, `rd_pulse`, `done_pulse` and `trc_cycle` are zero.
- R2: An instruction that meets no hazard follows fixed stage timing. It issues in cycle t, reads its operands in t+1, pulses `done_pulse` in t+1+L and writes back in t+2+L, where L is the latency of its unit.
- R3: Operation class 0 (load) uses unit ID 1 with latency 1. Class 1 (multiply) uses unit ID 2 or 3 with latency 10, and the lower free ID is taken. Class 2 (add/subtract) uses unit ID 4 with latency 2. Class 3 (divide) uses unit ID 5 with latency 40. `iss_unit` reports the granted ID in the transfer cycle. Bit k of `rd_pulse` and `done_pulse` belongs to unit ID k+1.
- R4: An instruction whose destination has a pending writer does not issue (WAW). It issues in the cycle after that writer's write-back.
- R5: Issue is in order. While the head instruction is stalled, `in_ready` stays low and no later instruction is accepted, even when its unit is free.
- R6: An instruction whose unit classes are all busy stalls. A unit can be issued to again in the cycle after its write-back.
- R7: A unit reads operands only when no earlier unit still owes it a source value (RAW). The read happens in the cycle after the last such producer writes back. A producer that writes back in the same cycle as the consumer issues counts as already written.
- R8: Write-back of a unit is held while another unit has not yet read a source equal to this destination and has that source marked ready (WAR). It proceeds in the cycle after that read.
- R9: One write-back per cycle. When several units are eligible, the lowest unit ID wins. `wb_unit` and `wb_reg` give the winner's ID and destination register.
- R10: `trc_cycle` counts clock cycles since reset release, and each unit pulses `rd_pulse` exactly once per instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| in_cls | input | 2 | Operation class (0 load, 1 mul, 2 add/sub, 3 div) |
| in_dst | input | 5 | Destination register |
| in_src1 | input | 5 | First source register |
| in_src2 | input | 5 | Second source register |
| iss_unit | output | 3 | Unit ID granted at transfer, 0 otherwise |
| rd_pulse | output | 5 | Per-unit operand-read event |
| done_pulse | output | 5 | Per-unit execution-complete event |
| wb_valid | output | 1 | Register-file write granted this cycle |
| wb_unit | output | 3 | Unit ID writing back |
| wb_reg | output | 5 | Register being written |
| trc_cycle | output | 16 | Cycles since reset release |

## Verification
A sweep of single instructions over every class and several destinations isolates the unit mapping and the latency, with no hazard involved. A six-instruction sequence mixing two loads, a multiply, a subtract, a divide and an add is compared against an arithmetically derived cycle table. It exercises RAW waits, a shared read in one cycle, a structural stall and a WAR-held write-back together. Short directed patterns separate the rest. A same-destination pair followed by an independent instruction shows the WAW stall and in-order blocking. Three multiplies in a row show selection between the multipliers. A multiply and an add timed to finish together show the write-back priority. A consumer issued exactly while its producer writes back shows that readiness is handed over in that cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NUM_MUL = 2;
  localparam int NUM_FU  = NUM_MUL + 3;
  localparam int UID_W   = $clog2(NUM_FU + 1);

  typedef enum logic [1:0] {
    CLS_LOAD = 2'd0,
    CLS_MUL  = 2'd1,
    CLS_ADD  = 2'd2,
    CLS_DIV  = 2'd3
  } op_cls_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_OPS  = 2'd1,
    PH_EXEC = 2'd2,
    PH_WB   = 2'd3
  } fu_phase_e;

  // unit index 0 is load, then the multipliers, then add, then divide
  function automatic op_cls_e fu_class(input int idx);
    if (idx == 0) return CLS_LOAD;
    else if (idx <= NUM_MUL) return CLS_MUL;
    else if (idx == NUM_MUL + 1) return CLS_ADD;
    else return CLS_DIV;
  endfunction
endpackage

// File: rtl/sb_fu_timer.sv
module sb_fu_timer #(
  parameter int LAT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (start) cnt <= CW'(LAT);
    else if (cnt != '0) cnt <= cnt - CW'(1);
  end

  assign done = (cnt == CW'(1));
endmodule

// File: rtl/sb_issue_sel.sv
module sb_issue_sel
  import sb_pkg::*;
(
  input  logic              in_valid,
  input  logic [1:0]        in_cls,
  input  logic              dst_pend,
  input  logic [NUM_FU-1:0] fu_busy,
  output logic              in_ready,
  output logic [NUM_FU-1:0] gnt
);
  logic [NUM_FU-1:0] cand;
  logic              found;

  always_comb begin
    gnt   = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_FU; i++) begin
      cand[i] = !fu_busy[i] && (fu_class(i) == op_cls_e'(in_cls));
      if (cand[i] && !found) begin
        gnt[i] = in_valid && !dst_pend;
        found  = 1'b1;
      end
    end
    in_ready = found && !dst_pend;
  end
endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb #(
  parameter int N = 5,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        gnt[i] = 1'b1;
        idx    = IW'(i);
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
#(
  parameter int NREG     = 32,
  parameter int LAT_LOAD = 1,
  parameter int LAT_MUL  = 10,
  parameter int LAT_ADD  = 2,
  parameter int LAT_DIV  = 40,
  parameter int TRC_W    = 16,
  localparam int REG_W   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_cls,
  input  logic [REG_W-1:0]  in_dst,
  input  logic [REG_W-1:0]  in_src1,
  input  logic [REG_W-1:0]  in_src2,
  output logic [UID_W-1:0]  iss_unit,
  output logic [NUM_FU-1:0] rd_pulse,
  output logic [NUM_FU-1:0] done_pulse,
  output logic              wb_valid,
  output logic [UID_W-1:0]  wb_unit,
  output logic [REG_W-1:0]  wb_reg,
  output logic [TRC_W-1:0]  trc_cycle
);
  localparam int IW = $clog2(NUM_FU);

  typedef logic [UID_W-1:0] uid_t;
  typedef logic [REG_W-1:0] reg_t;

  // per-unit status
  fu_phase_e phase [NUM_FU];
  reg_t      fi    [NUM_FU];
  reg_t      fj    [NUM_FU];
  reg_t      fk    [NUM_FU];
  uid_t      qj    [NUM_FU];
  uid_t      qk    [NUM_FU];
  logic [NUM_FU-1:0] rj, rk;

  // per-register pending writer, 0 = none
  uid_t rstat [NREG];

  logic [NUM_FU-1:0] busy, iss_gnt, rd_go, tmr_done, war_blk, wb_req, wb_gnt;
  logic [IW-1:0]     wb_idx;
  logic              wb_any;
  uid_t              q1, q2, wb_id, iss_id;
  logic              dst_pend;
  logic [TRC_W-1:0]  cyc_q;

  // hazard lookups at the issue point
  always_comb begin
    for (int i = 0; i < NUM_FU; i++) busy[i] = (phase[i] != PH_IDLE);
    dst_pend = (rstat[in_dst] != '0);
    wb_id    = wb_any ? (uid_t'(wb_idx) + uid_t'(1)) : '0;
    q1 = rstat[in_src1];
    if (wb_any && q1 == wb_id) q1 = '0;
    q2 = rstat[in_src2];
    if (wb_any && q2 == wb_id) q2 = '0;
    iss_id = '0;
    for (int i = 0; i < NUM_FU; i++)
      if (iss_gnt[i]) iss_id = uid_t'(i + 1);
  end

  sb_issue_sel u_iss (
    .in_valid (in_valid),
    .in_cls   (in_cls),
    .dst_pend (dst_pend),
    .fu_busy  (busy),
    .in_ready (in_ready),
    .gnt      (iss_gnt)
  );

  // operand read and WAR checks
  always_comb begin
    for (int i = 0; i < NUM_FU; i++) begin
      rd_go[i]   = (phase[i] == PH_OPS) && rj[i] && rk[i];
      war_blk[i] = 1'b0;
      for (int f = 0; f < NUM_FU; f++) begin
        if (f != i && phase[f] == PH_OPS &&
            ((fj[f] == fi[i] && rj[f]) || (fk[f] == fi[i] && rk[f])))
          war_blk[i] = 1'b1;
      end
      wb_req[i] = (phase[i] == PH_WB) && !war_blk[i];
    end
  end

  // execution latency per unit, chosen by unit class
  for (genvar g = 0; g < NUM_FU; g++) begin : g_fu
    localparam op_cls_e CLS_G = fu_class(g);
    localparam int LAT_G = (CLS_G == CLS_LOAD) ? LAT_LOAD :
                           (CLS_G == CLS_MUL)  ? LAT_MUL  :
                           (CLS_G == CLS_ADD)  ? LAT_ADD  : LAT_DIV;
    sb_fu_timer #(.LAT(LAT_G)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (rd_go[g]),
      .done  (tmr_done[g])
    );
  end

  sb_wb_arb #(.N(NUM_FU)) u_arb (
    .req (wb_req),
    .gnt (wb_gnt),
    .idx (wb_idx),
    .any (wb_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_FU; i++) begin
        phase[i] <= PH_IDLE;
        fi[i]    <= '0;
        fj[i]    <= '0;
        fk[i]    <= '0;
        qj[i]    <= '0;
        qk[i]    <= '0;
      end
      rj <= '0;
      rk <= '0;
      for (int r = 0; r < NREG; r++) rstat[r] <= '0;
      cyc_q <= '0;
    end else begin
      cyc_q <= cyc_q + TRC_W'(1);
      for (int i = 0; i < NUM_FU; i++) begin
        if (iss_gnt[i]) begin
          phase[i] <= PH_OPS;
          fi[i]    <= in_dst;
          fj[i]    <= in_src1;
          fk[i]    <= in_src2;
          qj[i]    <= q1;
          qk[i]    <= q2;
          rj[i]    <= (q1 == '0);
          rk[i]    <= (q2 == '0);
        end else begin
          if (rd_go[i]) begin
            phase[i] <= PH_EXEC;
            rj[i]    <= 1'b0;
            rk[i]    <= 1'b0;
          end
          if (tmr_done[i]) phase[i] <= PH_WB;
          if (wb_gnt[i])   phase[i] <= PH_IDLE;
          if (wb_any && phase[i] == PH_OPS) begin
            if (qj[i] == wb_id) begin
              rj[i] <= 1'b1;
              qj[i] <= '0;
            end
            if (qk[i] == wb_id) begin
              rk[i] <= 1'b1;
              qk[i] <= '0;
            end
          end
        end
      end
      if (wb_any) rstat[fi[wb_idx]] <= '0;
      if (|iss_gnt) rstat[in_dst] <= iss_id;
    end
  end

  assign iss_unit   = iss_id;
  assign rd_pulse   = rd_go;
  assign done_pulse = tmr_done;
  assign wb_valid   = wb_any;
  assign wb_unit    = wb_id;
  assign wb_reg     = wb_any ? fi[wb_idx] : '0;
  assign trc_cycle  = cyc_q;
endmodule

// File: rtl/sb_ctrl_chk.sv
module sb_ctrl_chk
  import sb_pkg::*;
#(
  parameter int TRC_W    = 16,
  parameter int LAT_LOAD = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [NUM_FU-1:0] rd_pulse,
  input logic [NUM_FU-1:0] done_pulse,
  input logic              wb_valid,
  input logic [UID_W-1:0]  wb_unit,
  input logic [TRC_W-1:0]  trc_cycle
);
  // stalled instruction stays offered until accepted
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> in_valid);

  // a granted write-back names a real unit
  assert_wb_unit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_unit >= UID_W'(1) && wb_unit <= UID_W'(NUM_FU)));

  // trace counter advances by one each cycle
  assert_trc_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (trc_cycle == $past(trc_cycle) + TRC_W'(1)));

  for (genvar g = 0; g < NUM_FU; g++) begin : g_unit
    assert_single_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pulse[g] |=> !rd_pulse[g]);

    assert_stage_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_unit == UID_W'(g + 1)) |-> (!rd_pulse[g] && !done_pulse[g]));
  end

  if (LAT_LOAD == 1) begin : g_ld1
    assert_load_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pulse[0] |=> done_pulse[0]);
  end
endmodule

bind sb_ctrl sb_ctrl_chk #(.TRC_W(TRC_W), .LAT_LOAD(LAT_LOAD)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .rd_pulse   (rd_pulse),
  .done_pulse (done_pulse),
  .wb_valid   (wb_valid),
  .wb_unit    (wb_unit),
  .trc_cycle  (trc_cycle)
);

// File: tb/sb_ctrl_tb.sv
`timescale 1ns/1ps
module sb_ctrl_tb;
  localparam int LL = 1;
  localparam int LM = 10;
  localparam int LA = 2;
  localparam int LD = 40;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready;
  logic [1:0] in_cls;
  logic [4:0] in_dst, in_src1, in_src2, wb_reg;
  logic [2:0] iss_unit, wb_unit;
  logic [4:0] rd_pulse, done_pulse;
  logic       wb_valid;
  logic [15:0] trc_cycle;

  always #5 clk = ~clk;

  sb_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .iss_unit(iss_unit), .rd_pulse(rd_pulse), .done_pulse(done_pulse),
    .wb_valid(wb_valid), .wb_unit(wb_unit), .wb_reg(wb_reg), .trc_cycle(trc_cycle)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nseq = 0;
  int nwb = 0;
  int iss_c [64];
  int rd_c  [64];
  int dn_c  [64];
  int wb_c  [64];
  int wb_r  [64];
  int iss_u [64];
  int owner [8];

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else cyc <= cyc + 1;
  end

  // event recorder, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (in_valid && in_ready) begin
        iss_c[nseq] = cyc;
        iss_u[nseq] = int'(iss_unit);
        owner[iss_unit] = nseq;
        nseq = nseq + 1;
      end
      for (int u = 0; u < 5; u++) begin
        if (rd_pulse[u])   rd_c[owner[u+1]] = cyc;
        if (done_pulse[u]) dn_c[owner[u+1]] = cyc;
      end
      if (wb_valid) begin
        wb_c[owner[wb_unit]] = cyc;
        wb_r[owner[wb_unit]] = int'(wb_reg);
        nwb = nwb + 1;
      end
    end
  end

  task automatic chk(input int act, input int exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lat_of(input int c);
    return (c == 0) ? LL : (c == 1) ? LM : (c == 2) ? LA : LD;
  endfunction

  function automatic int unit_of(input int c);
    return (c == 0) ? 1 : (c == 1) ? 2 : (c == 2) ? 4 : 5;
  endfunction

  task automatic send(input int c, input int d, input int s1, input int s2);
    in_valid = 1'b1;
    in_cls   = 2'(c);
    in_dst   = 5'(d);
    in_src1  = 5'(s1);
    in_src2  = 5'(s2);
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain();
    while (nwb < nseq) @(posedge clk);
    @(negedge clk);
    chk(int'(trc_cycle), cyc, "R10", "cycle counter");
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s, b, d;
    int e_iss[6], e_rd[6], e_dn[6], e_wb[6];
    rst_n = 1'b0; in_valid = 1'b0; in_cls = '0;
    in_dst = '0; in_src1 = '0; in_src2 = '0;
    repeat (3) @(negedge clk);
    chk(int'(in_ready), 1, "R1", "ready in reset");
    chk(int'(wb_valid), 0, "R1", "wb in reset");
    chk(int'(rd_pulse), 0, "R1", "rd in reset");
    chk(int'(done_pulse), 0, "R1", "done in reset");
    chk(int'(trc_cycle), 0, "R1", "trace in reset");
    rst_n = 1'b1;
    @(posedge clk); #1;

    // sweep: every class, several destinations, no hazards
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < 3; k++) begin
        d = (k == 2) ? 31 : k * 15;
        s = nseq;
        send(c, d, (d + 1) % 32, (d + 2) % 32);
        drain();
        chk(rd_c[s] - iss_c[s], 1, "R2", "issue to read");
        chk(dn_c[s] - rd_c[s], lat_of(c), "R3", "read to done");
        chk(wb_c[s] - dn_c[s], 1, "R2", "done to write");
        chk(wb_r[s], d, "R9", "written register");
        chk(iss_u[s], unit_of(c), "R3", "unit choice");
      end
    end

    // six-instruction mixed sequence against a derived cycle table
    s = nseq;
    send(0, 6, 31, 31);
    send(0, 2, 31, 31);
    send(1, 0, 2, 4);
    send(2, 8, 6, 2);
    send(3, 10, 0, 6);
    send(2, 6, 8, 2);
    drain();
    b = iss_c[s] - 1;
    e_iss[0] = 1;            e_rd[0] = 2;            e_dn[0] = e_rd[0] + LL; e_wb[0] = e_dn[0] + 1;
    e_iss[1] = e_wb[0] + 1;  e_rd[1] = e_iss[1] + 1; e_dn[1] = e_rd[1] + LL; e_wb[1] = e_dn[1] + 1;
    e_iss[2] = e_iss[1] + 1; e_rd[2] = e_wb[1] + 1;  e_dn[2] = e_rd[2] + LM; e_wb[2] = e_dn[2] + 1;
    e_iss[3] = e_iss[2] + 1; e_rd[3] = e_wb[1] + 1;  e_dn[3] = e_rd[3] + LA; e_wb[3] = e_dn[3] + 1;
    e_iss[4] = e_iss[3] + 1; e_rd[4] = e_wb[2] + 1;  e_dn[4] = e_rd[4] + LD; e_wb[4] = e_dn[4] + 1;
    e_iss[5] = e_wb[3] + 1;  e_rd[5] = e_iss[5] + 1; e_dn[5] = e_rd[5] + LA; e_wb[5] = e_rd[4] + 1;
    for (int i = 0; i < 6; i++) begin
      chk(iss_c[s+i] - b, e_iss[i], "R6", "table issue");
      chk(rd_c[s+i] - b, e_rd[i], "R7", "table read");
      chk(dn_c[s+i] - b, e_dn[i], "R2", "table done");
      chk(wb_c[s+i] - b, e_wb[i], "R8", "table write");
    end

    // same destination twice, independent instruction behind
    s = nseq;
    send(3, 3, 30, 30);
    send(2, 3, 29, 29);
    send(1, 9, 28, 28);
    drain();
    chk(iss_c[s+1] - iss_c[s], LD + 3, "R4", "WAW issue");
    chk(iss_c[s+2] - iss_c[s+1], 1, "R5", "in-order follower");
    chk(iss_u[s+2], 2, "R3", "follower unit");

    // three multiplies in a row
    s = nseq;
    send(1, 10, 28, 28);
    send(1, 11, 28, 28);
    send(1, 12, 28, 28);
    drain();
    chk(iss_u[s], 2, "R3", "first multiplier");
    chk(iss_u[s+1], 3, "R3", "second multiplier");
    chk(iss_u[s+2], 2, "R6", "reuse multiplier");
    chk(iss_c[s+1] - iss_c[s], 1, "R6", "second issue");
    chk(iss_c[s+2] - iss_c[s], LM + 3, "R6", "structural stall");

    // multiply and add become eligible together
    s = nseq;
    send(1, 13, 28, 28);
    idle(LM - LA - 1);
    send(2, 14, 27, 27);
    drain();
    chk(iss_c[s+1] - iss_c[s], LM - LA, "R9", "aligned issue");
    chk(wb_c[s] - iss_c[s], LM + 2, "R9", "low ID first");
    chk(wb_c[s+1] - iss_c[s+1], LA + 3, "R9", "high ID next");

    // consumer issues while its producer writes back
    s = nseq;
    send(0, 15, 31, 31);
    idle(LL + 1);
    send(2, 16, 15, 15);
    drain();
    chk(iss_c[s+1], wb_c[s], "R7", "issue at producer write");
    chk(rd_c[s+1] - iss_c[s+1], 1, "R7", "read after handover");
    chk(wb_c[s+1] - iss_c[s+1], LA + 2, "R2", "consumer write");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule